// File: doc/BRIEF.md
# Logarithmic-depth carry-lookahead adder

This block adds two unsigned or two's-complement operands of a power-of-two width together with a carry input. It returns the wrapped sum and the carry leaving the top bit. The datapath has no clock and no stored state. Each bit first forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). A binary tree of combining cells then merges neighbouring spans pairwise until a single span covers the whole word. That takes log2(WIDTH) levels.

A second pass walks the same tree from the root back to the leaves. The root's incoming carry is the adder's carry input. A lower child inherits its parent's incoming carry. An upper child receives the carry that leaves its lower sibling's span, computed from that sibling's group terms. Each leaf's incoming carry is XORed with that bit's propagate term to give the sum bit. Carry delay therefore grows with the tree depth rather than with the word length.

The block is meant to be dropped into a wider datapath wherever a single-cycle add is needed at widths where a ripple chain is too slow.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin`, with the operands taken as unsigned integers.
- R2: `cout` equals bit WIDTH of the (WIDTH+1)-bit unsigned total `a + b + cin`.
- R3: Every sum bit k equals `a[k] ^ b[k] ^ c(k)`. Here c(0) is `cin`, and for k > 0, c(k) is bit k of the unsigned total of `a[k-1:0] + b[k-1:0] + cin`.
- R4: When every bit position propagates (`b == ~a`), `cout` equals `cin`. In that case `sum` is all ones when `cin` is 0 and all zeros when `cin` is 1.
- R5: The longest carry chain resolves correctly: with `a` all ones, `b` zero and `cin` 1, `sum` is zero and `cout` is 1.
- R6: When both operands have their top bit set, `cout` is 1 whatever the other bits. When both have their top bit clear, `cout` is 0.
- R7: The outputs depend only on the present inputs. A new input value is reflected at the outputs within the same cycle, with no register in the path.
- R8: The same description is correct at widths of 8, 16 (default) and 32. WIDTH must be a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | first operand |
| b | input | WIDTH | second operand |
| cin | input | 1 | carry into bit 0 |
| sum | output | WIDTH | wrapped sum |
| cout | output | 1 | carry out of the top bit |

## Verification
The bound checker compares every output change against a plain behavioural addition of the same inputs. It also checks the per-bit relation between the lowest sum bit and the carry input, the all-propagate case, and the top-bit generate and kill cases. The bench's scenarios cover what a single snapshot cannot. These are the exhaustive sweep at width 8, random sweeps at widths 16 and 32, the worst-case carry chain, the per-bit carry relation at every bit position, and the fact that a changed input shows up at the outputs without any clock edge between.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Group terms of one span of bit positions
    typedef struct packed {
        logic g;   // span produces a carry on its own
        logic p;   // span passes its incoming carry through
    } span_t;

    // Join a lower span with the adjacent higher span
    function automatic span_t span_join(span_t lo, span_t hi);
        span_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = lo.p & hi.p;
        return r;
    endfunction

    // Carry that leaves a span, given the carry that enters it
    function automatic logic span_carry(span_t s, logic c_in);
        return s.g | (s.p & c_in);
    endfunction

endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    output span_t [WIDTH-1:0] bit_span
);

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        assign bit_span[k].g = a[k] & b[k];
        assign bit_span[k].p = a[k] ^ b[k];
    end

endmodule

// File: rtl/cla_merge_tree.sv
// Upward pass: heap-ordered node array, node 1 is the whole word,
// node i covers the spans of nodes 2i (lower) and 2i+1 (upper),
// leaf for bit k sits at index WIDTH+k.
module cla_merge_tree
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  span_t [WIDTH-1:0]   bit_span,
    output span_t [2*WIDTH-1:1] node
);

    localparam int LEVELS = $clog2(WIDTH);

    for (genvar k = 0; k < WIDTH; k++) begin : g_leaf
        assign node[WIDTH+k] = bit_span[k];
    end

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        for (genvar j = 0; j < (1 << lv); j++) begin : g_cell
            localparam int IDX = (1 << lv) + j;
            assign node[IDX] = span_join(node[2*IDX], node[2*IDX+1]);
        end
    end

endmodule

// File: rtl/cla_carry_tree.sv
// Downward pass: hands each node the carry entering its span.
module cla_carry_tree
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  span_t [2*WIDTH-2:1] node,
    input  logic                cin,
    output logic  [WIDTH-1:0]   carry,
    output logic                cout
);

    localparam int LEVELS = $clog2(WIDTH);

    logic [2*WIDTH-1:1] c_node;

    assign c_node[1] = cin;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        for (genvar j = 0; j < (1 << lv); j++) begin : g_cell
            localparam int IDX = (1 << lv) + j;
            assign c_node[2*IDX]   = c_node[IDX];
            assign c_node[2*IDX+1] = span_carry(node[2*IDX], c_node[IDX]);
        end
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_out
        assign carry[k] = c_node[WIDTH+k];
    end

    assign cout = span_carry(node[1], cin);

endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    span_t [WIDTH-1:0]   bit_span;
    span_t [2*WIDTH-1:1] node;
    logic  [WIDTH-1:0]   carry;

    cla_bit_terms #(.WIDTH(WIDTH)) u_terms (
        .a        (a),
        .b        (b),
        .bit_span (bit_span)
    );

    cla_merge_tree #(.WIDTH(WIDTH)) u_up (
        .bit_span (bit_span),
        .node     (node)
    );

    cla_carry_tree #(.WIDTH(WIDTH)) u_down (
        .node  (node[2*WIDTH-2:1]),
        .cin   (cin),
        .carry (carry),
        .cout  (cout)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_sum
        assign sum[k] = bit_span[k].p ^ carry[k];
    end

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        // R1
        p_sum_match_r1: assert (sum == ref_total[WIDTH-1:0])
            else $error("sum mismatch");
        // R2
        p_cout_match_r2: assert (cout == ref_total[WIDTH])
            else $error("cout mismatch");
        // R3: bit 0 takes the carry input directly
        p_lsb_r3: assert (sum[0] == (a[0] ^ b[0] ^ cin))
            else $error("lsb mismatch");
        // R4
        if ((a ^ b) == '1) begin
            p_all_prop_r4: assert (cout == cin && sum == {WIDTH{~cin}})
                else $error("all-propagate mismatch");
        end
        // R6
        if (a[WIDTH-1] && b[WIDTH-1]) begin
            p_top_gen_r6: assert (cout)
                else $error("top generate lost");
        end
        if (!a[WIDTH-1] && !b[WIDTH-1]) begin
            p_top_kill_r6: assert (!cout)
                else $error("top kill violated");
        end
    end

endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/sim_cla_adder.sv
`timescale 1ns/1ps
module sim_cla_adder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    logic [7:0]  a8,  b8,  s8;
    logic [15:0] a16, b16, s16;
    logic [31:0] a32, b32, s32;
    logic        c8, c16, c32, co8, co16, co32;

    cla_adder #(.WIDTH(16)) u0 (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16));
    cla_adder #(.WIDTH(8))  u1 (.a(a8),  .b(b8),  .cin(c8),  .sum(s8),  .cout(co8));
    cla_adder #(.WIDTH(32)) u2 (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one width, compare sum (R1) and cout (R2) with a plain addition
    task automatic apply(int w, logic [31:0] x, logic [31:0] y, logic ci, string tag);
        logic [32:0] mask, tot;
        logic [31:0] act_s;
        logic        act_c;
        mask = (33'd1 << w) - 33'd1;
        tot  = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {32'd0, ci};
        case (w)
            8:  begin a8  = x[7:0];  b8  = y[7:0];  c8  = ci; end
            16: begin a16 = x[15:0]; b16 = y[15:0]; c16 = ci; end
            default: begin a32 = x; b32 = y; c32 = ci; end
        endcase
        #1;
        case (w)
            8:  begin act_s = {24'd0, s8};  act_c = co8;  end
            16: begin act_s = {16'd0, s16}; act_c = co16; end
            default: begin act_s = s32; act_c = co32; end
        endcase
        check({tag, " R1 sum"},  {32'd0, act_s}, {32'd0, tot[31:0] & mask[31:0]});
        check({tag, " R2 cout"}, {63'd0, act_c}, {63'd0, tot[w]});
    endtask

    task automatic t_zero();
        @(negedge clk);
        apply(8,  0, 0, 0, "zero");
        apply(16, 0, 0, 0, "zero");
        apply(32, 0, 0, 0, "zero");
    endtask

    task automatic t_exhaustive8();   // R8 at width 8
        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                for (int ci = 0; ci < 2; ci++) begin
                    @(negedge clk);
                    apply(8, x, y, ci[0], "R8 w8");
                end
    endtask

    task automatic t_random(int w, int n);   // R8 at 16 and 32
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            apply(w, $urandom, $urandom, $urandom_range(0, 1), "R8 rnd");
        end
    endtask

    task automatic t_bit_carry_r3();
        for (int i = 0; i < 200; i++) begin
            logic [15:0] x, y;
            logic ci;
            x = $urandom; y = $urandom; ci = $urandom_range(0, 1);
            @(negedge clk);
            a16 = x; b16 = y; c16 = ci;
            #1;
            for (int k = 0; k < 16; k++) begin
                logic [16:0] part, m;
                logic ck;
                m    = (17'd1 << k) - 17'd1;
                part = ({1'b0, x} & m) + ({1'b0, y} & m) + {16'd0, ci};
                ck   = part[k];
                check("R3 bit", {63'd0, s16[k]}, {63'd0, x[k] ^ y[k] ^ ck});
            end
        end
    endtask

    task automatic t_all_prop_r4();
        for (int i = 0; i < 20; i++) begin
            logic [15:0] x;
            x = $urandom;
            for (int ci = 0; ci < 2; ci++) begin
                @(negedge clk);
                a16 = x; b16 = ~x; c16 = ci[0];
                #1;
                check("R4 cout", {63'd0, co16}, {63'd0, ci[0]});
                check("R4 sum", {48'd0, s16}, ci[0] ? 64'd0 : 64'hFFFF);
            end
        end
    endtask

    task automatic t_long_chain_r5();
        @(negedge clk);
        a8 = 8'hFF; b8 = 0; c8 = 1; a16 = 16'hFFFF; b16 = 0; c16 = 1;
        a32 = 32'hFFFF_FFFF; b32 = 0; c32 = 1;
        #1;
        check("R5 sum8",  {56'd0, s8},  0);
        check("R5 cout8", {63'd0, co8}, 1);
        check("R5 sum16", {48'd0, s16}, 0);
        check("R5 cout16", {63'd0, co16}, 1);
        check("R5 sum32", {32'd0, s32}, 0);
        check("R5 cout32", {63'd0, co32}, 1);
        // mirror case: b carries the ones
        @(negedge clk);
        a16 = 0; b16 = 16'hFFFF; c16 = 1;
        #1;
        check("R5 sum16b",  {48'd0, s16},  0);
        check("R5 cout16b", {63'd0, co16}, 1);
    endtask

    task automatic t_top_bits_r6();
        for (int i = 0; i < 50; i++) begin
            logic [15:0] x, y;
            x = $urandom; y = $urandom;
            @(negedge clk);
            a16 = x | 16'h8000; b16 = y | 16'h8000; c16 = $urandom_range(0, 1);
            #1;
            check("R6 gen", {63'd0, co16}, 1);
            @(negedge clk);
            a16 = x & 16'h7FFF; b16 = y & 16'h7FFF; c16 = 1;
            #1;
            check("R6 kill", {63'd0, co16}, 0);
        end
    endtask

    task automatic t_no_clock_r7();
        // two changes inside one clock half-period, no edge between
        @(posedge clk);
        #1;
        a16 = 16'h1234; b16 = 16'h0FFF; c16 = 0;
        #1;
        check("R7 first", {47'd0, co16, s16}, 64'h2233);
        a16 = 16'hF000; b16 = 16'h1000; c16 = 1;
        #1;
        check("R7 second", {47'd0, co16, s16}, 64'h10001);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        a8 = 0; b8 = 0; c8 = 0; a16 = 0; b16 = 0; c16 = 0; a32 = 0; b32 = 0; c32 = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_zero();
        t_long_chain_r5();
        t_all_prop_r4();
        t_top_bits_r6();
        t_bit_carry_r3();
        t_no_clock_r7();
        t_random(16, 2000);
        t_random(32, 2000);
        t_exhaustive8();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule